// File: doc/BRIEF.md
# Cascaded Audio Clock Divider

This block derives the master clock and the serial bit clock for one audio direction from a single reference clock. The reference first passes through an optional divide-by-8 prescaler and then a programmable main divider. A fixed divide-by-2 stage follows and produces the master clock. A programmable fine divider then turns the master clock into the bit clock. Divide values are held as N-1 in their fields, so a field value of 0 selects divide-by-1.

A bypass select sends the reference straight to the master clock, with no division. This mode is meant for a reference that comes from an external crystal. In bypass only the fine divider acts, and it sets the bit clock directly from the reference. A direction bit decides whether the master-clock pad is driven by the chain or used as an input. When the pad is an input, the chain sits idle and the external clock is passed on as the block's master clock.

The divider settings are sampled only at the start of a bit-clock period. Software can therefore rewrite them while the clocks run, and no shortened pulse appears.

Top module: `audclk_divchain`

## Requirements
- R1: While rst_n is low, bclk_o and mclk_pad_o are 0, and mclk_pad_oe equals cfg_mclk_dir.
- R2: With cfg_div8 = 1 the prescaler divides by 8, so every master-clock and bit-clock phase lasts 8 times as many reference cycles as with cfg_div8 = 0.
- R3: The main stage divides by cfg_main_div + 1, which covers 1 to 256. The ratios 1 and 256 are both usable.
- R4: Outside bypass, the master clock on mclk_pad_o has a period of 2·P·M reference cycles, where P is 1 or 8 and M is the main divide value. This gives even ratios from 2 to 4096. The clock is high for the first P·M cycles after a period start and low for the next P·M cycles.
- R5: Outside bypass, the bit clock has a period of F master-clock periods, where F = cfg_fine_div + 1 (1 to 16). It is high for F·P·M cycles and then low for F·P·M cycles. It rises together with the master clock, and the fine stage never acts on the master clock.
- R6: With cfg_bypass = 1, mclk_pad_o is the reference clock itself. bclk_o is the reference divided by F: high for ceil(F/2) cycles and low for floor(F/2) cycles, and equal to the reference when F = 1. cfg_div8 and cfg_main_div have no effect in this mode.
- R7: With cfg_mclk_dir = 0 (pad is an input), mclk_pad_oe is 0, mclk_o follows mclk_pad_i, and bclk_o and mclk_pad_o stay 0. With cfg_mclk_dir = 1, mclk_pad_oe is 1 and mclk_o equals mclk_pad_o. At the first clock edge after the bit goes to 1, both clocks start in their high phase.
- R8: A change to cfg_div8, cfg_main_div, cfg_fine_div or cfg_bypass made during a bit-clock period does not affect that period. The new settings take effect from the next bit-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that feeds the divider chain |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div8 | input | 1 | 1 selects the divide-by-8 prescaler, 0 passes the reference through |
| cfg_main_div | input | MAIN_W | Main divide value minus one |
| cfg_fine_div | input | FINE_W | Bit-clock fine divide value minus one |
| cfg_bypass | input | 1 | 1 routes the reference to the master clock undivided |
| cfg_mclk_dir | input | 1 | Master-clock pad direction: 1 drive, 0 input |
| mclk_pad_i | input | 1 | External master clock when the pad is an input |
| mclk_pad_o | output | 1 | Master clock generated by the chain |
| mclk_pad_oe | output | 1 | Pad output enable |
| mclk_o | output | 1 | Master clock used by the block's serializer |
| bclk_o | output | 1 | Serial bit clock |

## Verification
The bench sweeps every fine value from 1 to 16 against main values 1, 2, 3 and 7, once with the prescaler off and once with it on. For each setting it predicts every sample of both clocks from the products P·M and P·M·F. This separates errors in each stage's count, in the order of the stages and in duty cycle from one another. Runs at main value 256 test the largest ratios. A bypass sweep over all fine values, with deliberately odd prescaler and main settings, shows that those settings are ignored and that odd fine ratios give the longer high phase. A setting change in mid-period, and a pass with the pad set as input, test the reload point and the pass-through path.

// File: rtl/acd_pkg.sv
`timescale 1ns/1ps
package acd_pkg;
    // Direction of the master-clock pad
    typedef enum logic {
        PAD_INPUT  = 1'b0,
        PAD_OUTPUT = 1'b1
    } pad_dir_e;
endpackage

// File: rtl/acd_stage_cnt.sv
`timescale 1ns/1ps
// One counting stage of the divider cascade: advances on en, returns to
// zero on wrap or on a synchronous clear.
module acd_stage_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         wrap,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = wrap ? '0 : cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/audclk_divchain.sv
`timescale 1ns/1ps
module audclk_divchain
    import acd_pkg::*;
#(
    parameter int MAIN_W   = 8,
    parameter int FINE_W   = 4,
    parameter int PRE_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_div8,
    input  logic [MAIN_W-1:0] cfg_main_div,
    input  logic [FINE_W-1:0] cfg_fine_div,
    input  logic              cfg_bypass,
    input  logic              cfg_mclk_dir,
    input  logic              mclk_pad_i,
    output logic              mclk_pad_o,
    output logic              mclk_pad_oe,
    output logic              mclk_o,
    output logic              bclk_o
);
    // fine counter spans 2F master half-periods; compare needs one more bit
    localparam int FC_W = FINE_W + 1;
    localparam int HI_W = FINE_W + 2;

    typedef struct packed {
        logic              div8;
        logic [MAIN_W-1:0] main;
        logic [FINE_W-1:0] fine;
        logic              byp;
    } shadow_t;

    typedef struct packed {
        logic    run;
        logic    hck;
        logic    bclk;
        shadow_t sh;
    } state_t;

    state_t            st_d, st_q;
    pad_dir_e          dir;
    logic              dir_out;
    logic              pre_wrap, pre_tick;
    logic [MAIN_W-1:0] main_cnt;
    logic              main_wrap, main_tick;
    logic [FC_W-1:0]   fine_cnt, fine_last;
    logic              fine_wrap, fine_step;
    logic [HI_W-1:0]   fine_nxt, hi_lim;
    logic              load, chain_clr;
    logic              chain_clk;

    assign dir     = pad_dir_e'(cfg_mclk_dir);
    assign dir_out = (dir == PAD_OUTPUT);

    // ---------------- stage 1: prescaler ----------------
    generate
        if (PRE_LOG2 > 0) begin : g_pre
            logic [PRE_LOG2-1:0] pre_cnt, pre_last;
            assign pre_last = st_q.sh.div8 ? '1 : '0;
            assign pre_wrap = (pre_cnt == pre_last);
            acd_stage_cnt #(.W(PRE_LOG2)) u_pre (
                .clk  (clk),
                .rst_n(rst_n),
                .clr  (chain_clr),
                .en   (st_q.run),
                .wrap (pre_wrap),
                .cnt  (pre_cnt)
            );
        end else begin : g_nopre
            assign pre_wrap = 1'b1;
        end
    endgenerate

    assign pre_tick = st_q.run & pre_wrap;

    // ---------------- stage 2: main divider ----------------
    assign main_wrap = (main_cnt == st_q.sh.main);
    assign main_tick = pre_tick & main_wrap;

    acd_stage_cnt #(.W(MAIN_W)) u_main (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (chain_clr),
        .en   (pre_tick),
        .wrap (main_wrap),
        .cnt  (main_cnt)
    );

    // ---------------- stage 4: fine divider ----------------
    // normal: counts master half-periods, 2F per bit period
    // bypass: counts reference cycles, F per bit period
    assign fine_step = st_q.run & (st_q.sh.byp | main_tick);
    assign fine_last = st_q.sh.byp ? {1'b0, st_q.sh.fine} : {st_q.sh.fine, 1'b1};
    assign fine_wrap = (fine_cnt == fine_last);
    assign fine_nxt  = HI_W'(fine_cnt) + HI_W'(1);
    assign hi_lim    = st_q.sh.byp ? HI_W'((HI_W'(st_q.sh.fine) + HI_W'(2)) >> 1)
                                   : HI_W'(st_q.sh.fine) + HI_W'(1);

    acd_stage_cnt #(.W(FC_W)) u_fine (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (chain_clr),
        .en   (fine_step),
        .wrap (fine_wrap),
        .cnt  (fine_cnt)
    );

    // reload settings at each bit-clock rising edge
    assign load      = dir_out & (~st_q.run | (fine_step & fine_wrap));
    assign chain_clr = load | ~dir_out;

    always_comb begin
        st_d = st_q;
        if (!dir_out) begin
            st_d.run  = 1'b0;
            st_d.hck  = 1'b0;
            st_d.bclk = 1'b0;
        end else if (load) begin
            st_d.run     = 1'b1;
            st_d.hck     = 1'b1;
            st_d.bclk    = 1'b1;
            st_d.sh.div8 = cfg_div8;
            st_d.sh.main = cfg_main_div;
            st_d.sh.fine = cfg_fine_div;
            st_d.sh.byp  = cfg_bypass;
        end else begin
            // stage 3: fixed divide-by-2
            if (main_tick) begin
                st_d.hck = ~st_q.hck;
            end
            if (fine_step) begin
                st_d.bclk = (fine_nxt < hi_lim);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        chain_clk = st_q.run & (st_q.sh.byp ? clk : st_q.hck);
        bclk_o    = st_q.run & ((st_q.sh.byp && (st_q.sh.fine == '0)) ? clk : st_q.bclk);
    end

    assign mclk_pad_o  = chain_clk;
    assign mclk_pad_oe = dir_out;
    assign mclk_o      = dir_out ? chain_clk : mclk_pad_i;
endmodule

// File: rtl/acd_chk.sv
`timescale 1ns/1ps
module acd_chk #(
    parameter int SH_W = 14,
    parameter int FC_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_mclk_dir,
    input logic            run_q,
    input logic            hck_q,
    input logic            bclk_q,
    input logic            byp_q,
    input logic [SH_W-1:0] sh_bits,
    input logic [FC_W-1:0] fine_cnt
);
    // R7: an input-direction pad parks the chain
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mclk_dir |=> (!run_q && !hck_q && !bclk_q));

    // R7: chain start puts both clocks into their high phase together
    a_r7_aligned_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> (hck_q && bclk_q));

    // R8: sampled settings only move when a bit period restarts
    a_r8_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_cnt != '0) |-> $stable(sh_bits));

    // R5: every bit-clock edge coincides with a master-clock edge
    a_r5_edge_align: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !byp_q && !$past(byp_q) && !$stable(bclk_q))
        |-> !$stable(hck_q));
endmodule

bind audclk_divchain acd_chk #(
    .SH_W(MAIN_W + FINE_W + 2),
    .FC_W(FINE_W + 1)
) u_acd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mclk_dir(cfg_mclk_dir),
    .run_q       (st_q.run),
    .hck_q       (st_q.hck),
    .bclk_q      (st_q.bclk),
    .byp_q       (st_q.sh.byp),
    .sh_bits     (st_q.sh),
    .fine_cnt    (fine_cnt)
);

// File: tb/test_audclk_divchain.sv
`timescale 1ns/1ps
module test_audclk_divchain;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_div8 = 1'b0;
    logic [7:0] cfg_main_div = 8'd0;
    logic [3:0] cfg_fine_div = 4'd0;
    logic       cfg_bypass = 1'b0;
    logic       cfg_mclk_dir = 1'b0;
    logic       mclk_pad_i = 1'b0;
    logic       mclk_pad_o, mclk_pad_oe, mclk_o, bclk_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    audclk_divchain i_audclk_divchain (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_div8    (cfg_div8),
        .cfg_main_div(cfg_main_div),
        .cfg_fine_div(cfg_fine_div),
        .cfg_bypass  (cfg_bypass),
        .cfg_mclk_dir(cfg_mclk_dir),
        .mclk_pad_i  (mclk_pad_i),
        .mclk_pad_o  (mclk_pad_o),
        .mclk_pad_oe (mclk_pad_oe),
        .mclk_o      (mclk_o),
        .bclk_o      (bclk_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // restart the chain with a setting and compare every sample arithmetically
    task automatic run_cfg(input bit div8, input int m, input int f, input bit byp,
                           input string mreq);
        int p = div8 ? 8 : 1;
        int pm = p * m;
        int nsamp = byp ? 4 * f : 4 * pm * f;
        int bad_m = 0;
        int bad_b = 0;
        @(negedge clk); #1;
        cfg_mclk_dir = 1'b0;
        cfg_div8     = div8;
        cfg_main_div = 8'(m - 1);
        cfg_fine_div = 4'(f - 1);
        cfg_bypass   = byp;
        @(negedge clk); #1;
        cfg_mclk_dir = 1'b1;
        for (int i = 0; i < nsamp; i++) begin
            logic em, eb;
            @(negedge clk); #1;
            if (byp) begin
                em = 1'b0;
                eb = (f == 1) ? 1'b0 : ((i % f) < (f + 1) / 2);
            end else begin
                em = ((i / pm) % 2) == 0;
                eb = ((i / (pm * f)) % 2) == 0;
            end
            if (mclk_o !== em || mclk_pad_o !== em || mclk_pad_oe !== 1'b1) bad_m++;
            if (bclk_o !== eb) bad_b++;
        end
        if (byp) begin
            @(posedge clk); #2;
            if (mclk_o !== 1'b1) bad_m++;
            if (f == 1 && bclk_o !== 1'b1) bad_b++;
        end
        chk(byp ? "R6" : mreq,
            $sformatf("mclk bad samples m=%0d f=%0d div8=%0d byp=%0d", m, f, div8, byp), bad_m, 0);
        chk(byp ? "R6" : "R5",
            $sformatf("bclk bad samples m=%0d f=%0d div8=%0d byp=%0d", m, f, div8, byp), bad_b, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int ms[4] = '{1, 2, 3, 7};
        int bad;
        // R1: reset state, pad as input then as output
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "bclk_o in reset", int'(bclk_o), 0);
        chk("R1", "mclk_pad_o in reset", int'(mclk_pad_o), 0);
        chk("R1", "mclk_pad_oe in reset dir=0", int'(mclk_pad_oe), 0);
        cfg_mclk_dir = 1'b1;
        @(negedge clk); #1;
        chk("R1", "mclk_pad_oe in reset dir=1", int'(mclk_pad_oe), 1);
        chk("R1", "bclk_o in reset dir=1", int'(bclk_o), 0);
        chk("R1", "mclk_pad_o in reset dir=1", int'(mclk_pad_o), 0);
        cfg_mclk_dir = 1'b0;
        rst_n = 1'b1;

        // R7: input direction passes the external clock through
        cfg_main_div = 8'd0;
        cfg_fine_div = 4'd0;
        mclk_pad_i   = 1'b1;
        bad = 0;
        repeat (6) begin
            @(negedge clk); #1;
            if (bclk_o !== 1'b0 || mclk_pad_o !== 1'b0 || mclk_pad_oe !== 1'b0) bad++;
        end
        chk("R7", "outputs driven while pad is input", bad, 0);
        chk("R7", "mclk_o follows pad high", int'(mclk_o), 1);
        mclk_pad_i = 1'b0;
        #1;
        chk("R7", "mclk_o follows pad low", int'(mclk_o), 0);

        // R2 R3 R4 R5: sweep prescaler, main and fine values
        for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < 4; k++) begin
                for (int f = 1; f <= 16; f++) begin
                    run_cfg(d[0], ms[k], f, 1'b0, d ? "R2 R4" : "R3 R4");
                end
            end
        end
        // R3 R4: largest main value, largest master ratio
        run_cfg(1'b1, 256, 1, 1'b0, "R3 R4");
        run_cfg(1'b0, 256, 16, 1'b0, "R3 R4");

        // R6: bypass with prescaler and main settings that must be ignored
        for (int f = 1; f <= 16; f++) begin
            run_cfg(f[0], f * 5, f, 1'b1, "R6");
        end

        // R8: mid-period change waits for the next bit-clock rising edge
        run_cfg(1'b0, 2, 2, 1'b0, "R4");
        @(negedge clk); #1;
        cfg_mclk_dir = 1'b0;
        @(negedge clk); #1;
        cfg_mclk_dir = 1'b1;
        bad = 0;
        for (int i = 0; i < 24; i++) begin
            logic em, eb;
            @(negedge clk); #1;
            if (i < 16) begin
                em = ((i / 2) % 2) == 0;
                eb = ((i / 4) % 2) == 0;
            end else begin
                em = ((i - 16) % 2) == 0;
                eb = em;
            end
            if (mclk_o !== em || bclk_o !== eb) bad++;
            if (i == 9) begin
                cfg_main_div = 8'd0;
                cfg_fine_div = 4'd0;
            end
        end
        chk("R8", "bad samples around mid-period change", bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule